// File: doc/BRIEF.md
# Hardware Breakpoint Watch Unit

This block sits beside a processor core's address generation and watches every address the core issues. Software loads up to four breakpoint addresses and a control word. The control word arms each breakpoint for the current task only or for all tasks, and picks which kind of access it reacts to. When an armed breakpoint sees an equal address with an agreeing access kind, the unit raises a debug exception request (vector 1) on the following cycle. It also records the cause in a sticky status word, which the exception handler reads.

Two further trap sources feed the same exception and status word: a single-step trap and a trap on switching into a task marked for trapping. A task-switch strobe disarms every breakpoint that was armed for the current task only. A guard bit in the control word protects the debug registers. While the guard is set, any write to them is refused and reported as a debug exception, and the guard clears itself so that the handler can get in.

Top module: `bkpt_watch_unit`

## Requirements
- R1: After a synchronous reset, all four breakpoint addresses, the control word and the status word read as zero, and `dbg_exc` is low.
- R2: The register selector maps 0 to 3 to breakpoint addresses 0 to 3, 4 to the control word and 5 to the status word. Selectors 6 and 7 read zero and ignore writes. The control word keeps only bits 0 to 7, bit 13 and bits 16+4n to 17+4n for n = 0 to 3. Every other bit reads zero. A written value is used by the comparators from the next cycle on.
- R3: Breakpoint n hits when `acc_valid` is high, `acc_addr` equals its address, and its access code at control bits 17+4n:16+4n agrees with `acc_kind`. Code 00 agrees with fetch (kind 00). Code 01 agrees with write (kind 01). Code 11 agrees with write or read (kind 10). Code 10 never agrees. Kind 11 is an idle slot and never hits.
- R4: A breakpoint whose local enable (control bit 2n) and global enable (control bit 2n+1) are both clear never hits.
- R5: Status bit n is set on the edge after breakpoint n hits. Several of these bits can be set in the same cycle.
- R6: Status bit 14 is set on the edge after `step_trap`. Status bit 15 is set on the edge after `task_trap`.
- R7: Status bits stay set until software writes selector 5. The write loads the value masked to bits 0 to 3 and 13 to 15, and any causes in the same cycle are ORed on top. All other status bits read zero.
- R8: `dbg_exc` is high in exactly the cycle after a cycle with at least one cause (a breakpoint hit, a step trap, a task trap or a guard trip).
- R9: On `task_switch`, control bits 0, 2, 4 and 6 clear on the next edge, and the global enables are kept.
- R10: While control bit 13 is set, a write to selectors 0 to 5 is refused. It sets status bit 13, clears control bit 13 and counts as a cause for R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_sel` |
| acc_valid | input | 1 | An address is issued this cycle |
| acc_addr | input | ADDR_W | Linear address issued by the core |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 write, 10 read, 11 idle |
| step_trap | input | 1 | Single-step trap event |
| task_trap | input | 1 | Switch into a task whose trap bit is set |
| task_switch | input | 1 | Any task switch; disarms local enables |
| dbg_exc | output | 1 | Debug exception request, one cycle after a cause |

## Verification
The hardest situation to reach from the ports is a cycle in which several causes coincide with a register write. Examples are two breakpoints hitting together while a step trap fires and software clears the status word, or a refused write under the guard landing on the same edge as a task switch. The directed part programs two breakpoints with the same address and compatible access codes to force a double hit, and it lines up a status clear with a hit. The random part draws addresses from the programmed pool, so hits are frequent. It also lets register writes, guard settings, trap strobes and task switches fall on the same cycles as accesses, and compares each edge with a bench model.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int BP_SLOTS         = 4;
    localparam int REG_W            = 32;
    localparam int SEL_W            = 3;
    localparam int IDX_W            = $clog2(BP_SLOTS);
    localparam int CTRL_TYPE_LSB    = 16;
    localparam int CTRL_TYPE_STRIDE = 4;
    localparam int CTRL_GUARD_BIT   = 13;
    localparam int STAT_GUARD_BIT   = 13;
    localparam int STAT_STEP_BIT    = 14;
    localparam int STAT_TASK_BIT    = 15;

    localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(4);
    localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(5);

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_READ  = 2'b10,
        KIND_IDLE  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        TRIG_FETCH = 2'b00,
        TRIG_WRITE = 2'b01,
        TRIG_NONE  = 2'b10,
        TRIG_DATA  = 2'b11
    } trig_e;

    typedef struct packed {
        logic  loc_en;
        logic  glb_en;
        trig_e trig;
    } slot_cfg_t;

    typedef struct packed {
        logic                task_trap;
        logic                step_trap;
        logic                guard_trip;
        logic [BP_SLOTS-1:0] bp_hit;
    } cause_t;

    // Does an access of kind k satisfy trigger code t?
    function automatic logic trig_agrees(trig_e t, acc_kind_e k);
        logic ok;
        unique case (t)
            TRIG_FETCH: ok = (k == KIND_FETCH);
            TRIG_WRITE: ok = (k == KIND_WRITE);
            TRIG_DATA:  ok = (k == KIND_WRITE) || (k == KIND_READ);
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Bits of the control word that hold state.
    function automatic logic [REG_W-1:0] ctrl_keep_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int n = 0; n < BP_SLOTS; n++) begin
            m[2*n]                                  = 1'b1;
            m[2*n+1]                                = 1'b1;
            m[CTRL_TYPE_LSB+CTRL_TYPE_STRIDE*n +: 2] = 2'b11;
        end
        m[CTRL_GUARD_BIT] = 1'b1;
        return m;
    endfunction

    // Bits of the control word that arm a slot for the current task only.
    function automatic logic [REG_W-1:0] local_en_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int n = 0; n < BP_SLOTS; n++) m[2*n] = 1'b1;
        return m;
    endfunction

    // Map causes onto status word bit positions.
    function automatic logic [REG_W-1:0] stat_image(cause_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[BP_SLOTS-1:0]  = c.bp_hit;
        w[STAT_GUARD_BIT] = c.guard_trip;
        w[STAT_STEP_BIT]  = c.step_trap;
        w[STAT_TASK_BIT]  = c.task_trap;
        return w;
    endfunction

    localparam logic [REG_W-1:0] CTRL_KEEP = ctrl_keep_mask();
    localparam logic [REG_W-1:0] LOC_MASK  = local_en_mask();
    localparam logic [REG_W-1:0] STAT_KEEP = stat_image(cause_t'('1));

endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                task_switch,
    output logic [ADDR_W-1:0]   bp_addr  [BP_SLOTS],
    output slot_cfg_t           slot_cfg [BP_SLOTS],
    output logic                guard_trip,
    output logic [REG_W-1:0]    ctrl_word
);

    logic [ADDR_W-1:0] addr_q [BP_SLOTS];
    logic [REG_W-1:0]  ctrl_q;
    logic [REG_W-1:0]  ctrl_nxt;
    logic              wr_ok;

    // A guarded write to any live register is refused and reported.
    assign guard_trip = wr_en && ctrl_q[CTRL_GUARD_BIT] && (wr_sel <= SEL_STAT);
    assign wr_ok      = wr_en && !guard_trip;

    always_comb begin
        ctrl_nxt = ctrl_q;
        if (wr_ok && wr_sel == SEL_CTRL) begin
            ctrl_nxt = wr_data & CTRL_KEEP;
        end else if (guard_trip) begin
            ctrl_nxt[CTRL_GUARD_BIT] = 1'b0;
        end
        if (task_switch) begin
            ctrl_nxt = ctrl_nxt & ~LOC_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            for (int n = 0; n < BP_SLOTS; n++) addr_q[n] <= '0;
        end else begin
            ctrl_q <= ctrl_nxt;
            for (int n = 0; n < BP_SLOTS; n++) begin
                if (wr_ok && wr_sel == SEL_W'(n)) addr_q[n] <= wr_data[ADDR_W-1:0];
            end
        end
    end

    always_comb begin
        for (int n = 0; n < BP_SLOTS; n++) begin
            bp_addr[n]         = addr_q[n];
            slot_cfg[n].loc_en = ctrl_q[2*n];
            slot_cfg[n].glb_en = ctrl_q[2*n+1];
            slot_cfg[n].trig   = trig_e'(ctrl_q[CTRL_TYPE_LSB+CTRL_TYPE_STRIDE*n +: 2]);
        end
    end

    assign ctrl_word = ctrl_q;

    // R9: a task switch leaves no slot armed for the current task only
    a_r9_local_cleared: assert property (@(posedge clk) disable iff (rst)
        task_switch |=> (ctrl_word & LOC_MASK) == '0);

    // R9: global enables survive a task switch that has no register write
    a_r9_global_kept: assert property (@(posedge clk) disable iff (rst)
        (task_switch && !wr_en) |=> (ctrl_word & ~LOC_MASK) == ($past(ctrl_word) & ~LOC_MASK));

    // R10: a refused write drops the guard
    a_r10_guard_drops: assert property (@(posedge clk) disable iff (rst)
        guard_trip |=> !ctrl_word[CTRL_GUARD_BIT]);

    for (genvar n = 0; n < BP_SLOTS; n++) begin : g_guard_chk
        // R10: breakpoint addresses are untouched by a refused write
        a_r10_addr_held: assert property (@(posedge clk) disable iff (rst)
            guard_trip |=> $stable(addr_q[n]));
    end

endmodule

// File: rtl/bkpt_slot_match.sv
module bkpt_slot_match
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  acc_kind_e         acc_kind,
    input  logic [ADDR_W-1:0] bp_addr,
    input  slot_cfg_t         cfg,
    output logic              hit
);

    logic armed;
    logic addr_eq;
    logic kind_ok;

    always_comb begin
        armed   = cfg.loc_en || cfg.glb_en;
        addr_eq = (acc_addr == bp_addr);
        kind_ok = trig_agrees(cfg.trig, acc_kind);
        hit     = acc_valid && armed && addr_eq && kind_ok;
    end

    always_comb begin
        // R3: the reserved trigger code never produces a hit
        if (cfg.trig == TRIG_NONE) a_r3_never_code: assert (!hit);
        // R4: a disarmed slot stays silent
        if (!cfg.loc_en && !cfg.glb_en) a_r4_disarmed_quiet: assert (!hit);
    end

endmodule

// File: rtl/bkpt_cause_log.sv
module bkpt_cause_log
    import bkpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cause_t           cause,
    input  logic             sw_load,
    input  logic [REG_W-1:0] sw_data,
    output logic [REG_W-1:0] stat_word,
    output logic             exc_pulse
);

    logic [REG_W-1:0] stat_q;
    logic             exc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            exc_q  <= 1'b0;
        end else begin
            stat_q <= (sw_load ? (sw_data & STAT_KEEP) : stat_q) | stat_image(cause);
            exc_q  <= |cause;
        end
    end

    assign stat_word = stat_q;
    assign exc_pulse = exc_q;

    // R7: without a software load no status bit ever falls
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        !sw_load |=> (stat_word & $past(stat_word)) == $past(stat_word));

    // R7: unused status bits stay zero
    a_r7_zero_bits: assert property (@(posedge clk) disable iff (rst)
        (stat_word & ~STAT_KEEP) == '0);

    // R5: every hitting slot is logged on the next edge
    a_r5_hit_logged: assert property (@(posedge clk) disable iff (rst)
        (|cause.bp_hit) |=> (stat_word[BP_SLOTS-1:0] & $past(cause.bp_hit)) == $past(cause.bp_hit));

    // R8: exception follows any cause, and only a cause
    a_r8_exc_on_cause: assert property (@(posedge clk) disable iff (rst)
        (|cause) |=> exc_pulse);
    a_r8_exc_quiet: assert property (@(posedge clk) disable iff (rst)
        !(|cause) |=> !exc_pulse);

endmodule

// File: rtl/bkpt_watch_unit.sv
module bkpt_watch_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              step_trap,
    input  logic              task_trap,
    input  logic              task_switch,
    output logic              dbg_exc
);

    logic [ADDR_W-1:0]   bp_addr  [BP_SLOTS];
    slot_cfg_t           slot_cfg [BP_SLOTS];
    logic                guard_trip;
    logic [REG_W-1:0]    ctrl_word;
    logic [REG_W-1:0]    stat_word;
    logic [BP_SLOTS-1:0] hit_vec;
    cause_t              cause;
    logic                sw_load;
    acc_kind_e           kind;

    assign kind = acc_kind_e'(acc_kind);

    bkpt_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr),
        .wr_sel      (reg_sel),
        .wr_data     (reg_wdata),
        .task_switch (task_switch),
        .bp_addr     (bp_addr),
        .slot_cfg    (slot_cfg),
        .guard_trip  (guard_trip),
        .ctrl_word   (ctrl_word)
    );

    for (genvar n = 0; n < BP_SLOTS; n++) begin : g_slot
        bkpt_slot_match #(.ADDR_W(ADDR_W)) u_match (
            .acc_valid (acc_valid),
            .acc_addr  (acc_addr),
            .acc_kind  (kind),
            .bp_addr   (bp_addr[n]),
            .cfg       (slot_cfg[n]),
            .hit       (hit_vec[n])
        );
    end

    always_comb begin
        cause.bp_hit     = hit_vec;
        cause.guard_trip = guard_trip;
        cause.step_trap  = step_trap;
        cause.task_trap  = task_trap;
    end

    assign sw_load = reg_wr && (reg_sel == SEL_STAT) && !guard_trip;

    bkpt_cause_log u_log (
        .clk       (clk),
        .rst       (rst),
        .cause     (cause),
        .sw_load   (sw_load),
        .sw_data   (reg_wdata),
        .stat_word (stat_word),
        .exc_pulse (dbg_exc)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_sel < SEL_W'(BP_SLOTS)) begin
            reg_rdata = REG_W'(bp_addr[reg_sel[IDX_W-1:0]]);
        end else if (reg_sel == SEL_CTRL) begin
            reg_rdata = ctrl_word;
        end else if (reg_sel == SEL_STAT) begin
            reg_rdata = stat_word;
        end
    end

    // R3: no slot hits on an idle kind or without a valid address
    a_r3_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid || kind == KIND_IDLE) |-> hit_vec == '0);

    // R6: trap events land in their status bits
    a_r6_step_logged: assert property (@(posedge clk) disable iff (rst)
        step_trap |=> stat_word[STAT_STEP_BIT]);
    a_r6_task_logged: assert property (@(posedge clk) disable iff (rst)
        task_trap |=> stat_word[STAT_TASK_BIT]);

endmodule

// File: tb/test_bkpt_watch_unit.sv
`timescale 1ns/100ps
module test_bkpt_watch_unit;

    localparam logic [31:0] CMASK = 32'h3333_20FF;
    localparam logic [31:0] SMASK = 32'h0000_E00F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = 2'b11;
    logic        step_trap = 1'b0;
    logic        task_trap = 1'b0;
    logic        task_switch = 1'b0;
    logic        dbg_exc;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_addr [4];
    logic [31:0] m_ctrl;
    logic [31:0] m_stat;

    always #2.5 clk = ~clk;

    bkpt_watch_unit i_bkpt_watch_unit (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .step_trap(step_trap),
        .task_trap(task_trap), .task_switch(task_switch), .dbg_exc(dbg_exc)
    );

    function automatic logic agree(logic [1:0] t, logic [1:0] k);
        case (t)
            2'b00:   return k == 2'b00;
            2'b01:   return k == 2'b01;
            2'b11:   return (k == 2'b01) || (k == 2'b10);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] sel);
        if (sel < 3'd4) return m_addr[sel[1:0]];
        if (sel == 3'd4) return m_ctrl;
        if (sel == 3'd5) return m_stat;
        return 32'h0;
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock cycle of stimulus; the model advances alongside it.
    task automatic cyc(logic wr, logic [2:0] sel, logic [31:0] wd, logic av,
                       logic [31:0] ad, logic [1:0] k, logic st, logic tt, logic ts);
        logic        blocked;
        logic [31:0] c;
        logic [31:0] nctrl;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        acc_valid = av; acc_addr = ad; acc_kind = k;
        step_trap = st; task_trap = tt; task_switch = ts;
        blocked = wr && m_ctrl[13] && (sel <= 3'd5);
        c = '0;
        for (int n = 0; n < 4; n++) begin
            c[n] = av && (ad == m_addr[n]) && (m_ctrl[2*n] || m_ctrl[2*n+1])
                   && agree(m_ctrl[16+4*n +: 2], k);
        end
        c[13] = blocked; c[14] = st; c[15] = tt;
        @(posedge clk); #1;
        if (wr && !blocked && sel < 3'd4) m_addr[sel[1:0]] = wd;
        nctrl = m_ctrl;
        if (wr && !blocked && sel == 3'd4) nctrl = wd & CMASK;
        else if (blocked) nctrl[13] = 1'b0;
        if (ts) nctrl = nctrl & ~32'h0000_0055;
        m_ctrl = nctrl;
        m_stat = ((wr && !blocked && sel == 3'd5) ? (wd & SMASK) : m_stat) | c;
        check({31'b0, dbg_exc}, {31'b0, |c}, "R8 dbg_exc after cycle");
        reg_wr = 1'b0; acc_valid = 1'b0; acc_kind = 2'b11;
        step_trap = 1'b0; task_trap = 1'b0; task_switch = 1'b0;
    endtask

    task automatic rd(logic [2:0] sel, logic [31:0] exp, string tag);
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = sel;
        #0.5;
        check(reg_rdata, exp, tag);
    endtask

    task automatic wr_reg(logic [2:0] sel, logic [31:0] wd);
        cyc(1'b1, sel, wd, 1'b0, 32'h0, 2'b11, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic acc(logic [31:0] ad, logic [1:0] k);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, ad, k, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5417));
        for (int n = 0; n < 4; n++) m_addr[n] = '0;
        m_ctrl = '0; m_stat = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check({31'b0, dbg_exc}, 32'h0, "R1 dbg_exc after reset");
        for (int s = 0; s < 8; s++) rd(3'(s), 32'h0, "R1 register after reset");

        // R4: everything disarmed, address matches do nothing
        acc(32'h0, 2'b00);
        rd(3'd5, 32'h0, "R4 disarmed slot logs nothing");

        // R2: address registers and map
        wr_reg(3'd0, 32'h0000_1000);
        wr_reg(3'd1, 32'h0000_2000);
        wr_reg(3'd2, 32'h0000_3000);
        wr_reg(3'd3, 32'h0000_4000);
        for (int s = 0; s < 4; s++) rd(3'(s), 32'h1000 * (s + 1), "R2 address readback");
        wr_reg(3'd4, 32'hFFFF_DFFF);
        rd(3'd4, 32'h3333_00FF, "R2 control keeps only defined bits");
        wr_reg(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, 32'h0, "R2 selector 6 reads zero");
        rd(3'd0, 32'h0000_1000, "R2 selector 6 write leaves address 0");

        // slot0 local/fetch, slot1 global/write, slot2 local/data, slot3 global/code 10
        wr_reg(3'd4, 32'h2310_0099);
        rd(3'd4, 32'h2310_0099, "R2 control readback");
        wr_reg(3'd5, 32'h0);

        acc(32'h1000, 2'b00);
        rd(3'd5, 32'h0000_0001, "R3 fetch hit slot0");
        wr_reg(3'd5, 32'h0);
        acc(32'h1000, 2'b10);
        rd(3'd5, 32'h0, "R3 read does not match fetch code");
        acc(32'h1000, 2'b11);
        rd(3'd5, 32'h0, "R3 idle kind never hits");
        cyc(1'b0, 3'd0, 32'h0, 1'b0, 32'h1000, 2'b00, 1'b0, 1'b0, 1'b0);
        rd(3'd5, 32'h0, "R3 invalid access never hits");
        acc(32'h2000, 2'b01);
        rd(3'd5, 32'h0000_0002, "R3 write hit slot1");
        wr_reg(3'd5, 32'h0);
        acc(32'h3000, 2'b10);
        acc(32'h3000, 2'b00);
        rd(3'd5, 32'h0000_0004, "R3 data code hits read not fetch");
        wr_reg(3'd5, 32'h0);
        acc(32'h4000, 2'b01);
        acc(32'h4000, 2'b10);
        acc(32'h4000, 2'b00);
        rd(3'd5, 32'h0, "R3 code 10 never hits");

        // R2: new address is used from the next cycle
        cyc(1'b1, 3'd1, 32'h5000, 1'b1, 32'h5000, 2'b01, 1'b0, 1'b0, 1'b0);
        rd(3'd5, 32'h0, "R2 same-cycle write not yet compared");
        acc(32'h5000, 2'b01);
        rd(3'd5, 32'h0000_0002, "R2 new address compared next cycle");
        wr_reg(3'd5, 32'h0);

        // R5/R6: double hit plus both traps in one cycle
        wr_reg(3'd1, 32'h3000);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 32'h3000, 2'b01, 1'b1, 1'b1, 1'b0);
        rd(3'd5, 32'h0000_C006, "R5 R6 two slots and both traps logged");

        // R7: sticky, masked load, same-cycle OR
        acc(32'h9999, 2'b00);
        rd(3'd5, 32'h0000_C006, "R7 status sticky over idle cycles");
        wr_reg(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, 32'h0000_E00F, "R7 status write masked");
        cyc(1'b1, 3'd5, 32'h0, 1'b1, 32'h1000, 2'b00, 1'b0, 1'b0, 1'b0);
        rd(3'd5, 32'h0000_0001, "R7 hit survives same-cycle clear");
        wr_reg(3'd5, 32'h0);

        // R9: task switch disarms local enables only
        wr_reg(3'd1, 32'h2000);
        cyc(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 2'b11, 1'b0, 1'b0, 1'b1);
        rd(3'd4, 32'h2310_0088, "R9 local enables cleared");
        acc(32'h1000, 2'b00);
        rd(3'd5, 32'h0, "R9 local-only slot silent after switch");
        acc(32'h2000, 2'b01);
        rd(3'd5, 32'h0000_0002, "R9 global slot still hits");
        wr_reg(3'd5, 32'h0);

        // R10: guard refuses writes and trips
        wr_reg(3'd4, 32'h2310_2088);
        rd(3'd4, 32'h2310_2088, "R10 guard set");
        wr_reg(3'd0, 32'hDEAD_BEEF);
        rd(3'd0, 32'h0000_1000, "R10 guarded write refused");
        rd(3'd5, 32'h0000_2000, "R10 guard trip logged");
        rd(3'd4, 32'h2310_0088, "R10 guard cleared by trip");
        wr_reg(3'd0, 32'h0000_1100);
        rd(3'd0, 32'h0000_1100, "R10 write accepted after trip");

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            logic        w;
            logic [2:0]  s;
            logic [31:0] d;
            logic [31:0] a;
            w = ($urandom % 8) == 0;
            s = 3'($urandom % 8);
            d = $urandom;
            if (s < 3'd4) d = 32'h1000 * (($urandom % 4) + 1);
            if (s == 3'd4) d[13] = (($urandom % 8) == 0);
            a = (($urandom % 4) != 0) ? 32'h1000 * (($urandom % 4) + 1) : $urandom;
            cyc(w, s, d, ($urandom % 4) != 0, a, 2'($urandom % 4),
                ($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 32) == 0);
            if ((i % 64) == 63) begin
                for (int r = 0; r < 8; r++)
                    rd(3'(r), exp_read(3'(r)), "R2 R5 R7 R9 random readback");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule